// File: doc/BRIEF.md
# Processor Sleep State Sequencer

This block steps a processor through its four power levels. Level 0 is normal running. Level 1 is a halt that software requests; in that level the block drives none of its stop pins. Level 2 is the stop-grant state, where only the stop-clock pin is driven low. Level 3 is the suspend state. In level 3 the stop-clock and suspend-status pins go low one after the other. The suspend-status pin tells the memory controller to switch its refresh to a slow 32 kHz timebase. If the host-stop enable is set, the CPU-stop pin then also goes low so that the host clocks stop.

Entry is started by two read strobes, one for each of the two level registers. A single exit request brings the processor back to level 0. When the block leaves level 3 after the host clocks were stopped, it raises the CPU-stop pin first. It then waits for the processor PLL to relock for a cycle count taken from an input. Only after that wait do the suspend-status and stop-clock pins rise, together. All three pins are active low, and a 2-bit code reports the present level.

Top module: `cpu_sleep_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to level 0: `level_code`=0 and all three pins high.
- R2: A `lvl2_rd` pulse in level 0 gives, from the next cycle, `level_code`=2 with `stpclk_n` low and `cpustp_n` and `susst1_n` high.
- R3: In level 2, `exit_req` returns the block to level 0 on the next cycle, with all pins high.
- R4: A `halt_req` pulse in level 0 gives `level_code`=1 with all pins high, and `exit_req` then returns the block to level 0.
- R5: A `lvl3_rd` pulse in level 0 drives `stpclk_n` low in the first cycle and `susst1_n` low in the second. When `host_stop_en` is 1, `cpustp_n` goes low in the third cycle. `level_code` is 3 throughout.
- R6: With `host_stop_en`=0, `cpustp_n` stays high in level 3. An exit then raises `stpclk_n` and `susst1_n` together on the next cycle, with no wait.
- R7: On exit from level 3 with `cpustp_n` low, `cpustp_n` rises on the next cycle. `stpclk_n` and `susst1_n` stay low for `lock_wait`+1 cycles in all, then rise in the same cycle. `level_code` is 3 until they rise.
- R8: With `lock_wait`=0, the relock wait in R7 lasts exactly one cycle.
- R9: `lvl2_rd`, `lvl3_rd` and `halt_req` have no effect outside level 0. Pins and code stay unchanged.
- R10: In level 0, `lvl3_rd` wins over `lvl2_rd`, and either strobe wins over `halt_req`.
- R11: `exit_req` has no effect during the level 3 entry steps or in level 0, and the entry sequence goes on.
- R12: `level_code` is 0, 1, 2 or 3 for levels 0 to 3. It is 3 during level 3 entry and during the relock wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lvl2_rd | input | 1 | Strobe for a read of the level-2 register |
| lvl3_rd | input | 1 | Strobe for a read of the level-3 register |
| halt_req | input | 1 | Software halt request (enters level 1) |
| exit_req | input | 1 | Wake or exit event |
| host_stop_en | input | 1 | Stop the host clocks in level 3 |
| lock_wait | input | LOCK_W | PLL relock wait, in cycles |
| stpclk_n | output | 1 | Stop-clock pin, active low |
| cpustp_n | output | 1 | CPU clock-stop pin, active low |
| susst1_n | output | 1 | Suspend-status pin, active low |
| level_code | output | 2 | Present power level, 0 to 3 |

## Verification
The assertions assume that every input changes only between clock edges and is held steady over each edge. They also assume that `host_stop_en` does not change during a level 3 entry, and that `lock_wait` is stable on the cycle the exit is taken. The directed bench drives every input on the falling edge and samples on the next falling edge. It sets the enable and the wait count before each scenario starts and holds them until the block is back in level 0. Strobes and exit requests last one cycle each, unless a scenario deliberately holds them over an entry step.

// File: rtl/cpu_sleep_pkg.sv
package cpu_sleep_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_HALT,
    ST_GRANT,
    ST_ENT_STP,
    ST_ENT_SUS,
    ST_SUSP,
    ST_SUSP_HS,
    ST_RELOCK
  } seq_state_e;

  typedef struct packed {
    logic stpclk_n;
    logic cpustp_n;
    logic susst1_n;
  } pin_set_t;

  // Pin levels for each internal state, all active low.
  function automatic pin_set_t pins_for(seq_state_e s);
    pin_set_t p;
    p = '{stpclk_n: 1'b1, cpustp_n: 1'b1, susst1_n: 1'b1};
    case (s)
      ST_GRANT, ST_ENT_STP: p.stpclk_n = 1'b0;
      ST_ENT_SUS, ST_SUSP, ST_RELOCK: begin
        p.stpclk_n = 1'b0;
        p.susst1_n = 1'b0;
      end
      ST_SUSP_HS: begin
        p.stpclk_n = 1'b0;
        p.susst1_n = 1'b0;
        p.cpustp_n = 1'b0;
      end
      default: ;
    endcase
    return p;
  endfunction

  // Reported power level for each internal state.
  function automatic logic [1:0] level_of(seq_state_e s);
    case (s)
      ST_RUN:   return 2'd0;
      ST_HALT:  return 2'd1;
      ST_GRANT: return 2'd2;
      default:  return 2'd3;
    endcase
  endfunction

  // States in which an exit request is honoured.
  function automatic logic accepts_exit(seq_state_e s);
    return (s == ST_HALT) || (s == ST_GRANT) || (s == ST_SUSP) || (s == ST_SUSP_HS);
  endfunction

endpackage

// File: rtl/relock_timer.sv
module relock_timer #(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LOCK_W-1:0] load_val,
  input  logic              active,
  output logic              done
);

  logic [LOCK_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (active && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // The wait shortens by exactly one per cycle of the relock phase.
  p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
    (active && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // A loaded count is never skipped over.
  p_load_taken_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/sleep_state_fsm.sv
module sleep_state_fsm
  import cpu_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl2_rd,
  input  logic       lvl3_rd,
  input  logic       halt_req,
  input  logic       exit_req,
  input  logic       host_stop_en,
  input  logic       relock_done,
  output seq_state_e state,
  output logic       load_wait,
  output logic       in_relock
);

  seq_state_e state_q, state_d;

  // Named events, brought out for the checks below.
  logic take_exit, go_c3, go_c2, go_c1;

  assign take_exit = exit_req && accepts_exit(state_q);
  assign go_c3     = (state_q == ST_RUN) && lvl3_rd;
  assign go_c2     = (state_q == ST_RUN) && lvl2_rd && !lvl3_rd;
  assign go_c1     = (state_q == ST_RUN) && halt_req && !lvl2_rd && !lvl3_rd;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (go_c3)      state_d = ST_ENT_STP;
        else if (go_c2) state_d = ST_GRANT;
        else if (go_c1) state_d = ST_HALT;
      end
      ST_HALT, ST_GRANT, ST_SUSP:
        if (take_exit) state_d = ST_RUN;
      ST_ENT_STP: state_d = ST_ENT_SUS;
      ST_ENT_SUS: state_d = host_stop_en ? ST_SUSP_HS : ST_SUSP;
      ST_SUSP_HS:
        if (take_exit) state_d = ST_RELOCK;
      ST_RELOCK:
        if (relock_done) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  assign state     = state_q;
  assign load_wait = take_exit && (state_q == ST_SUSP_HS);
  assign in_relock = (state_q == ST_RELOCK);

  p_c2_entry_r2: assert property (@(posedge clk) disable iff (rst)
    go_c2 |=> (state_q == ST_GRANT));

  p_c3_priority_r10: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_RUN) && lvl3_rd && lvl2_rd) |=> (state_q == ST_ENT_STP));

  p_strobe_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_GRANT) && !exit_req) |=> (state_q == ST_GRANT));

  p_entry_proceeds_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ENT_STP) |=> (state_q == ST_ENT_SUS));

  p_no_wait_without_stop_r6: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SUSP) && exit_req) |=> (state_q == ST_RUN));

endmodule

// File: rtl/pin_decode.sv
module pin_decode
  import cpu_sleep_pkg::*;
(
  input  seq_state_e state,
  output logic       stpclk_n,
  output logic       cpustp_n,
  output logic       susst1_n,
  output logic [1:0] level_code
);

  pin_set_t pins;

  assign pins       = pins_for(state);
  assign stpclk_n   = pins.stpclk_n;
  assign cpustp_n   = pins.cpustp_n;
  assign susst1_n   = pins.susst1_n;
  assign level_code = level_of(state);

  // Pin nesting: deeper stop pins only ever assert under the shallower ones.
  always_comb begin
    p_pin_nesting_r5: assert ((cpustp_n || !susst1_n) && (susst1_n || !stpclk_n));
    p_halt_quiet_r4: assert ((level_code != 2'd1) || (stpclk_n && cpustp_n && susst1_n));
  end

endmodule

// File: rtl/cpu_sleep_seq.sv
module cpu_sleep_seq
  import cpu_sleep_pkg::*;
#(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lvl2_rd,
  input  logic              lvl3_rd,
  input  logic              halt_req,
  input  logic              exit_req,
  input  logic              host_stop_en,
  input  logic [LOCK_W-1:0] lock_wait,
  output logic              stpclk_n,
  output logic              cpustp_n,
  output logic              susst1_n,
  output logic [1:0]        level_code
);

  seq_state_e state;
  logic       load_wait, in_relock, relock_done;

  sleep_state_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .lvl2_rd      (lvl2_rd),
    .lvl3_rd      (lvl3_rd),
    .halt_req     (halt_req),
    .exit_req     (exit_req),
    .host_stop_en (host_stop_en),
    .relock_done  (relock_done),
    .state        (state),
    .load_wait    (load_wait),
    .in_relock    (in_relock)
  );

  relock_timer #(.LOCK_W(LOCK_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load_wait),
    .load_val (lock_wait),
    .active   (in_relock),
    .done     (relock_done)
  );

  pin_decode u_pins (
    .state      (state),
    .stpclk_n   (stpclk_n),
    .cpustp_n   (cpustp_n),
    .susst1_n   (susst1_n),
    .level_code (level_code)
  );

  // CPU-stop is always released while suspend status is still held.
  p_cpustp_first_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cpustp_n) |-> (!susst1_n && !stpclk_n));

  // Suspend status and stop-clock are released in the same cycle.
  p_release_together_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(susst1_n) |-> $rose(stpclk_n));

  // After reset the block reports level 0 with all pins high.
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (level_code == 2'd0 && stpclk_n && cpustp_n && susst1_n));

  // The code stays 3 while any suspend pin is held.
  p_code_deep_r12: assert property (@(posedge clk) disable iff (rst)
    !susst1_n |-> (level_code == 2'd3));

endmodule

// File: tb/test_cpu_sleep_seq.sv
module test_cpu_sleep_seq;

  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst, lvl2_rd, lvl3_rd, halt_req, exit_req, host_stop_en;
  logic [LW-1:0] lock_wait;
  logic stpclk_n, cpustp_n, susst1_n;
  logic [1:0] level_code;

  int n_checks = 0;
  int n_errors = 0;

  always #10 clk = ~clk;

  cpu_sleep_seq #(.LOCK_W(LW)) i_cpu_sleep_seq (
    .clk(clk), .rst(rst), .lvl2_rd(lvl2_rd), .lvl3_rd(lvl3_rd),
    .halt_req(halt_req), .exit_req(exit_req), .host_stop_en(host_stop_en),
    .lock_wait(lock_wait), .stpclk_n(stpclk_n), .cpustp_n(cpustp_n),
    .susst1_n(susst1_n), .level_code(level_code)
  );

  // Expected vector: {level code, stop-clock, cpu-stop, suspend-status}
  localparam logic [4:0] RUN   = {2'd0, 3'b111};
  localparam logic [4:0] HALT  = {2'd1, 3'b111};
  localparam logic [4:0] GRANT = {2'd2, 3'b011};
  localparam logic [4:0] E_STP = {2'd3, 3'b011};
  localparam logic [4:0] SUSP  = {2'd3, 3'b010};
  localparam logic [4:0] SUSHS = {2'd3, 3'b000};

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [4:0] exp);
    logic [4:0] got;
    got = {level_code, stpclk_n, cpustp_n, susst1_n};
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got code=%0d pins=%b, expected code=%0d pins=%b",
               req, got[4:3], got[2:0], exp[4:3], exp[2:0]);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step();
    check("R1 reset", RUN);
    rst = 1'b0; step();
    check("R1 idle after reset", RUN);
  endtask

  task automatic t_grant();
    lvl2_rd = 1'b1; step(); lvl2_rd = 1'b0;
    check("R2 level 2 entry", GRANT);
    step(); check("R2 level 2 held", GRANT);
    exit_req = 1'b1; step(); exit_req = 1'b0;
    check("R3 level 2 exit", RUN);
  endtask

  task automatic t_halt();
    halt_req = 1'b1; step(); halt_req = 1'b0;
    check("R4 halt entry, no pins", HALT);
    exit_req = 1'b1; step(); exit_req = 1'b0;
    check("R4 halt exit", RUN);
  endtask

  task automatic t_deep_stop(int wait_n, string tag);
    host_stop_en = 1'b1; lock_wait = LW'(wait_n);
    lvl3_rd = 1'b1; step(); lvl3_rd = 1'b0;
    check("R5 stop-clock first", E_STP);
    step(); check("R5 suspend second", SUSP);
    step(); check("R5 cpu-stop third", SUSHS);
    step(); check("R12 level 3 held", SUSHS);
    exit_req = 1'b1; step(); exit_req = 1'b0;
    for (int i = 0; i <= wait_n; i++) begin
      check(tag, SUSP);
      step();
    end
    check(tag, RUN);
    host_stop_en = 1'b0;
  endtask

  task automatic t_deep_nostop();
    host_stop_en = 1'b0; lock_wait = LW'(5);
    lvl3_rd = 1'b1; step(); lvl3_rd = 1'b0;
    check("R6 stop-clock first", E_STP);
    step(); check("R6 suspend, no cpu-stop", SUSP);
    step(); check("R6 cpu-stop stays high", SUSP);
    exit_req = 1'b1; step(); exit_req = 1'b0;
    check("R6 release with no wait", RUN);
  endtask

  task automatic t_ignore();
    lvl2_rd = 1'b1; step(); lvl2_rd = 1'b0;
    check("R9 in level 2", GRANT);
    lvl3_rd = 1'b1; halt_req = 1'b1; step(); lvl3_rd = 1'b0; halt_req = 1'b0;
    check("R9 strobes ignored in level 2", GRANT);
    exit_req = 1'b1; step(); exit_req = 1'b0;
    host_stop_en = 1'b1; lock_wait = '0;
    lvl3_rd = 1'b1; step(); lvl3_rd = 1'b0;
    step(); step();
    check("R9 in level 3", SUSHS);
    lvl2_rd = 1'b1; halt_req = 1'b1; step(); lvl2_rd = 1'b0; halt_req = 1'b0;
    check("R9 strobes ignored in level 3", SUSHS);
    exit_req = 1'b1; step(); exit_req = 1'b0;
    step(); check("R9 back to level 0", RUN);
    host_stop_en = 1'b0;
  endtask

  task automatic t_priority();
    lvl2_rd = 1'b1; lvl3_rd = 1'b1; halt_req = 1'b1; step();
    lvl2_rd = 1'b0; lvl3_rd = 1'b0; halt_req = 1'b0;
    check("R10 level 3 strobe wins", E_STP);
    step(); step();
    exit_req = 1'b1; step(); exit_req = 1'b0;
    check("R10 exit", RUN);
    lvl2_rd = 1'b1; halt_req = 1'b1; step();
    lvl2_rd = 1'b0; halt_req = 1'b0;
    check("R10 level 2 strobe beats halt", GRANT);
    exit_req = 1'b1; step(); exit_req = 1'b0;
  endtask

  task automatic t_exit_in_entry();
    exit_req = 1'b1; step();
    check("R11 exit ignored in level 0", RUN);
    exit_req = 1'b0;
    host_stop_en = 1'b1; lock_wait = LW'(1);
    lvl3_rd = 1'b1; step(); lvl3_rd = 1'b0;
    exit_req = 1'b1; step();
    check("R11 exit ignored at step 2", SUSP);
    step(); exit_req = 1'b0;
    check("R11 entry completes", SUSHS);
    step(); check("R11 level 3 resting", SUSHS);
    exit_req = 1'b1; step(); exit_req = 1'b0;
    step(); step();
    check("R11 exit after relock", RUN);
    host_stop_en = 1'b0;
  endtask

  initial begin
    int cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_checks++; n_errors++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_up();
      end
    end
  end

  initial begin
    rst = 1'b1; lvl2_rd = 1'b0; lvl3_rd = 1'b0; halt_req = 1'b0;
    exit_req = 1'b0; host_stop_en = 1'b0; lock_wait = '0;
    step();
    t_reset();
    t_grant();
    t_halt();
    t_deep_stop(3, "R7 relock wait of 4 cycles");
    t_deep_stop(0, "R8 zero wait gives one cycle");
    t_deep_nostop();
    t_ignore();
    t_priority();
    t_exit_in_entry();
    lvl3_rd = 1'b1; step(); lvl3_rd = 1'b0;
    rst = 1'b1; step(); rst = 1'b0;
    check("R1 reset during level 3 entry", RUN);
    finish_up();
  end

endmodule